// File: doc/BRIEF.md
# Packed BCD Addition Correction Unit

This block is a small accumulator datapath that adds two packed-BCD numbers in three operations. A load places the first BCD operand in the accumulator. A binary add then sums the accumulator and a second BCD byte as plain binary, and records a carry per digit. The top digit's carry is the carry flag and the lowest digit's carry is the auxiliary-carry flag. Finally, a correction add adds a decimal adjust value back into the accumulator. The result is a valid packed-BCD sum, and the carry flag holds the hundreds digit.

The adjust value is not a stored register. It is computed at every moment from the accumulator and the flags, and it appears on its own output. It therefore changes as soon as any of those change. The correction add sums it like any other operand. The carry from that add is merged into the carry left by the earlier binary add, so a decimal overflow from either step survives. Software-style use is load, add operand, add correction, with idle cycles allowed before the load and after the correction. Between the operand add and the correction add, an idle cycle holds all state, so the adjust value is unchanged. A load at that point would replace the accumulator.

The width is set by a digit-count parameter whose default is two digits (8 bits).

Top module: `bcd_add_corrector`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) clears the accumulator, the carry flag and the auxiliary-carry flag.
- R2: Operation code 2'b01 (load) writes the operand input into the accumulator and leaves the carry and auxiliary-carry flags unchanged.
- R3: Operation code 2'b10 (binary add) sets the accumulator to (accumulator + operand) mod 256. It sets the carry flag to the carry out of bit 7 and the auxiliary-carry flag to the carry out of bit 3.
- R4: The low nibble of the adjust output (bits 3:0) is 6 when the auxiliary-carry flag is 1 or accumulator bits 3:0 exceed 9, and 0 otherwise.
- R5: The high nibble of the adjust output (bits 7:4) is 6 when the carry flag is 1 or the accumulator exceeds 0x99, and 0 otherwise.
- R6: The adjust output follows the current accumulator and flags with no clock of latency. It is valid in the same cycle in which new state appears.
- R7: Operation code 2'b11 (correction add) sets the accumulator to (accumulator + adjust) mod 256 and ignores the operand input. The new carry flag is the old carry flag OR the carry out of bit 7. The new auxiliary-carry flag is the carry out of bit 3.
- R8: Operation code 2'b00 (idle) leaves the accumulator and both flags unchanged.
- R9: For any two valid two-digit BCD operands x and y, the sequence load x, binary add y, correction add leaves the accumulator holding (x+y) mod 100 in packed BCD. The carry flag is 1 exactly when x+y is at least 100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op | input | 2 | Operation: 00 idle, 01 load, 10 binary add, 11 correction add |
| operand | input | 8 | Data for load and binary add |
| acc | output | 8 | Accumulator |
| cy | output | 1 | Carry flag (top digit carry) |
| ac | output | 1 | Auxiliary-carry flag (low digit carry) |
| adj | output | 8 | Live decimal adjust value |

## Verification
The arithmetic assertions assume that op and operand are stable and known at each rising edge. The bench meets this by driving them only on the falling edge. The assertion that each adjust digit is 0 or 6 holds for any accumulator contents, so the random phase may load non-BCD bytes and run operations in any order. The decimal-result property, however, holds only when both operands are valid BCD and the three steps run in order. The exhaustive phase therefore draws x and y from 0 to 99 only. In that phase it drives a random operand on the correction add, which must be ignored.

// File: rtl/bcd_adj_pkg.sv
package bcd_adj_pkg;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_LOAD = 2'd1,
    OP_ADD  = 2'd2,
    OP_FIX  = 2'd3
  } op_e;

  // Adjust contribution of one digit: six when that digit carried out
  // or when the value up to and including it passed the all-nines mark.
  function automatic logic [3:0] digit_fix(input logic carried, input logic past_nines);
    return (carried || past_nines) ? 4'd6 : 4'd0;
  endfunction

  // One nibble of a ripple adder: returns {carry_out, sum_nibble}.
  function automatic logic [4:0] nib_add(input logic [3:0] x, input logic [3:0] y,
                                         input logic cin);
    return {1'b0, x} + {1'b0, y} + {4'd0, cin};
  endfunction

endpackage

// File: rtl/bcd_nib_adder.sv
module bcd_nib_adder #(
  parameter int DIGITS = 2,
  localparam int W = 4 * DIGITS
) (
  input  logic [W-1:0]      x,
  input  logic [W-1:0]      y,
  output logic [W-1:0]      sum,
  output logic [DIGITS-1:0] dcarry
);
  import bcd_adj_pkg::*;

  logic [DIGITS:0] chain;
  assign chain[0] = 1'b0;

  for (genvar k = 0; k < DIGITS; k++) begin : g_nib
    logic [4:0] part;
    assign part             = nib_add(x[4*k+3:4*k], y[4*k+3:4*k], chain[k]);
    assign sum[4*k+3:4*k]   = part[3:0];
    assign chain[k+1]       = part[4];
    assign dcarry[k]        = part[4];
  end

endmodule

// File: rtl/bcd_corr_gen.sv
module bcd_corr_gen #(
  parameter int DIGITS = 2,
  localparam int W = 4 * DIGITS
) (
  input  logic [W-1:0]      acc,
  input  logic [DIGITS-1:0] dcar,
  output logic [W-1:0]      adj
);
  import bcd_adj_pkg::*;

  for (genvar k = 0; k < DIGITS; k++) begin : g_dig
    localparam int PW = 4 * (k + 1);
    localparam logic [PW-1:0] NINES = {(k + 1){4'h9}};
    logic over_nines;
    assign over_nines          = acc[PW-1:0] > NINES;
    assign adj[4*k+3:4*k]      = digit_fix(dcar[k], over_nines);

    // Every adjust digit is either zero or six (R4, R5).
    always_comb begin
      p_fix_digit_r4: assert (adj[4*k+3:4*k] == 4'd0 || adj[4*k+3:4*k] == 4'd6);
    end
  end

  // A set top carry always forces six into the top adjust digit (R5).
  always_comb begin
    if (dcar[DIGITS-1]) p_top_fix_r5: assert (adj[W-1:W-4] == 4'd6);
  end

endmodule

// File: rtl/bcd_state_reg.sv
module bcd_state_reg #(
  parameter int DIGITS = 2,
  localparam int W = 4 * DIGITS
) (
  input  logic                   clk,
  input  logic                   rst,
  input  bcd_adj_pkg::op_e       op,
  input  logic [W-1:0]           operand,
  input  logic [W-1:0]           add_sum,
  input  logic [DIGITS-1:0]      add_car,
  output logic [W-1:0]           acc,
  output logic [DIGITS-1:0]      dcar
);
  import bcd_adj_pkg::*;

  // Carry set used by the correction add: the top carry is sticky.
  logic [DIGITS-1:0] fix_car;
  logic              top_carry_out;
  assign top_carry_out = add_car[DIGITS-1];

  always_comb begin
    fix_car             = add_car;
    fix_car[DIGITS-1]   = top_carry_out | dcar[DIGITS-1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc  <= '0;
      dcar <= '0;
    end else begin
      unique case (op)
        OP_LOAD: acc <= operand;
        OP_ADD: begin
          acc  <= add_sum;
          dcar <= add_car;
        end
        OP_FIX: begin
          acc  <= add_sum;
          dcar <= fix_car;
        end
        default: ;
      endcase
    end
  end

  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (acc == '0 && dcar == '0));

  p_load_keeps_flags_r2: assert property (@(posedge clk) disable iff (rst)
    op == OP_LOAD |=> (acc == $past(operand) && dcar == $past(dcar)));

  p_bin_add_r3: assert property (@(posedge clk) disable iff (rst)
    op == OP_ADD |=> ({dcar[DIGITS-1], acc} == ({1'b0, $past(acc)} + {1'b0, $past(operand)})));

  p_sticky_carry_r7: assert property (@(posedge clk) disable iff (rst)
    (op == OP_FIX && dcar[DIGITS-1]) |=> dcar[DIGITS-1]);

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
    op == OP_IDLE |=> ($stable(acc) && $stable(dcar)));

endmodule

// File: rtl/bcd_add_corrector.sv
module bcd_add_corrector #(
  parameter int DIGITS = 2,
  localparam int W = 4 * DIGITS
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [1:0]   op,
  input  logic [W-1:0] operand,
  output logic [W-1:0] acc,
  output logic         cy,
  output logic         ac,
  output logic [W-1:0] adj
);
  import bcd_adj_pkg::*;

  op_e               op_q;
  logic [W-1:0]      addend;
  logic [W-1:0]      add_sum;
  logic [DIGITS-1:0] add_car;
  logic [DIGITS-1:0] dcar;

  assign op_q   = op_e'(op);
  // The correction add takes the live adjust value; the operand is unused then.
  assign addend = (op_q == OP_FIX) ? adj : operand;

  bcd_nib_adder #(.DIGITS(DIGITS)) u_adder (
    .x      (acc),
    .y      (addend),
    .sum    (add_sum),
    .dcarry (add_car)
  );

  bcd_corr_gen #(.DIGITS(DIGITS)) u_corr (
    .acc  (acc),
    .dcar (dcar),
    .adj  (adj)
  );

  bcd_state_reg #(.DIGITS(DIGITS)) u_state (
    .clk     (clk),
    .rst     (rst),
    .op      (op_q),
    .operand (operand),
    .add_sum (add_sum),
    .add_car (add_car),
    .acc     (acc),
    .dcar    (dcar)
  );

  assign cy = dcar[DIGITS-1];
  assign ac = dcar[0];

  // The correction add never lowers the accumulator-plus-carry below
  // its previous value by more than the wrap, and ignores the operand (R7).
  p_fix_ignores_operand_r7: assert property (@(posedge clk) disable iff (rst)
    op_q == OP_FIX |=> acc == ($past(acc) + $past(adj)));

endmodule

// File: tb/bcd_add_corrector_tb.sv
module bcd_add_corrector_tb;

  logic       clk = 1'b0;
  logic       rst;
  logic [1:0] op;
  logic [7:0] operand;
  logic [7:0] acc;
  logic       cy;
  logic       ac;
  logic [7:0] adj;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  int m_a, m_cy, m_ac;

  always #10 clk = ~clk;

  bcd_add_corrector u_dut (
    .clk     (clk),
    .rst     (rst),
    .op      (op),
    .operand (operand),
    .acc     (acc),
    .cy      (cy),
    .ac      (ac),
    .adj     (adj)
  );

  function automatic int to_bcd(input int v);
    return (v / 10) * 16 + (v % 10);
  endfunction

  function automatic int exp_fix(input int a, input int c, input int h);
    int f;
    f = 0;
    if (h != 0 || (a % 16) > 9) f = f + 6;
    if (c != 0 || a > 153)      f = f + 96;
    return f;
  endfunction

  function automatic int pack_out(input int a, input int c, input int h, input int f);
    return (c << 17) | (h << 16) | (a << 8) | f;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic step(input logic [1:0] o, input logic [7:0] d);
    int s, f;
    @(negedge clk);
    op      = o;
    operand = d;
    @(posedge clk);
    #1;
    case (o)
      2'd1: m_a = d;
      2'd2: begin
        s    = m_a + d;
        m_ac = ((m_a % 16) + (d % 16)) > 15;
        m_cy = s > 255;
        m_a  = s % 256;
      end
      2'd3: begin
        f    = exp_fix(m_a, m_cy, m_ac);
        s    = m_a + f;
        m_ac = ((m_a % 16) + (f % 16)) > 15;
        m_cy = (m_cy != 0 || s > 255) ? 1 : 0;
        m_a  = s % 256;
      end
      default: ;
    endcase
  endtask

  task automatic chk_model(input string req);
    int act, expv;
    act  = pack_out(acc, cy, ac, adj);
    expv = pack_out(m_a, m_cy, m_ac, exp_fix(m_a, m_cy, m_ac));
    chk(act == expv, req, act, expv);
  endtask

  task automatic worked(input int x, input int y, input int a1, input int c1, input int h1,
                        input int f1, input int a2, input int c2, input int h2);
    step(2'd1, 8'(x));
    step(2'd2, 8'(y));
    chk(pack_out(acc, cy, ac, adj) == pack_out(a1, c1, h1, f1), "R3 R4 R5 worked add",
        pack_out(acc, cy, ac, adj), pack_out(a1, c1, h1, f1));
    step(2'd3, 8'hA5);
    chk(pack_out(acc, cy, ac, 0) == pack_out(a2, c2, h2, 0), "R7 R9 worked fix",
        pack_out(acc, cy, ac, 0), pack_out(a2, c2, h2, 0));
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd7321));
    rst = 1'b1; op = 2'd0; operand = 8'd0;
    m_a = 0; m_cy = 0; m_ac = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R1: reset state
    chk(pack_out(acc, cy, ac, adj) == 0, "R1 reset", pack_out(acc, cy, ac, adj), 0);

    // Worked cases (R3, R4, R5, R7, R9)
    worked(8'h99, 8'h89, 8'h22, 1, 1, 8'h66, 8'h88, 1, 0);
    worked(8'h85, 8'h15, 8'h9A, 0, 0, 8'h66, 8'h00, 1, 1);
    worked(8'h80, 8'h80, 8'h00, 1, 0, 8'h60, 8'h60, 1, 0);

    // R2: load keeps flags (cy=1, ac=0 after last case); R6: adjust live at once
    step(2'd1, 8'h0A);
    chk(pack_out(acc, cy, ac, adj) == pack_out(8'h0A, 1, 0, 8'h66), "R2 R6 load",
        pack_out(acc, cy, ac, adj), pack_out(8'h0A, 1, 0, 8'h66));
    // R8: idle holds with a busy operand
    step(2'd0, 8'hFF);
    chk(pack_out(acc, cy, ac, adj) == pack_out(8'h0A, 1, 0, 8'h66), "R8 idle",
        pack_out(acc, cy, ac, adj), pack_out(8'h0A, 1, 0, 8'h66));
    // R1: reset mid-stream clears state
    @(negedge clk); rst = 1'b1; @(posedge clk); #1; @(negedge clk); rst = 1'b0; #1;
    m_a = 0; m_cy = 0; m_ac = 0;
    chk(pack_out(acc, cy, ac, adj) == 0, "R1 reset after use", pack_out(acc, cy, ac, adj), 0);
    // R6/R4: low nibble over nine with clear flags
    step(2'd1, 8'h3C);
    chk(adj == 8'h06, "R4 R6 low digit", adj, 8'h06);
    step(2'd1, 8'hA3);
    chk(adj == 8'h60, "R5 R6 high digit", adj, 8'h60);

    // R9: exhaustive BCD pairs, random operand on the fix step (R7 ignore)
    for (int x = 0; x < 100; x++) begin
      for (int y = 0; y < 100; y++) begin
        int s;
        s = x + y;
        step(2'd1, 8'(to_bcd(x)));
        step(2'd2, 8'(to_bcd(y)));
        step(2'd3, 8'($urandom));
        chk(pack_out(acc, cy, 0, 0) == pack_out(to_bcd(s % 100), s >= 100, 0, 0),
            "R9 decimal sum", pack_out(acc, cy, 0, 0), pack_out(to_bcd(s % 100), s >= 100, 0, 0));
      end
    end

    // Random operation mix against the bench model (R2, R3, R7, R8)
    for (int i = 0; i < 3000; i++) begin
      step(2'($urandom), 8'($urandom));
      chk_model("R2 R3 R7 R8 random mix");
    end

    done = 1'b1;
    finish_run();
  end

endmodule